// File: doc/BRIEF.md
# Sub-Word Load/Store Alignment Unit

This unit sits between a processor's load/store stage and a data memory whose words are little-endian. It handles byte, halfword and full-word transfers. For a store it takes the low-order bytes of the source register and copies them into every lane of the write data. It then builds a byte-enable mask so that only the addressed lane or lanes are written. For a load it takes the addressed byte, halfword or full word from the fetched memory word, moves it to the bottom of the result, and extends it to the full width with either zeros or copies of its top bit.

The unit also checks alignment. A halfword must sit on an even address. A full word must sit on an offset of zero within the memory word. An access that breaks either rule, or that uses the reserved size code, raises a fault flag. A faulting access writes no bytes and returns a zero load result. Each request is registered, so its response appears one clock cycle after the request is presented. Lane k carries data bits [8k+7:8k] and is chosen by the low address bits.

Top module: `lsa_unit`

## Requirements
- R1: While reset is held, and in any cycle with no response, `rsp_valid` is 0, `rsp_fault` is 0 and `rsp_be` is all zeros.
- R2: A request accepted on a rising edge with `req_valid` high produces `rsp_valid` high right after that edge, and only then.
- R3: A byte store (size code 0) sets exactly the enable bit of lane `addr[1:0]`, and each lane of `rsp_wdata` carries `st_data[7:0]`.
- R4: A halfword store (size code 1) at an even offset enables lanes off and off+1, and each 16-bit half of `rsp_wdata` carries `st_data[15:0]`.
- R5: A full-word store (size code 2) at offset 0 enables every lane and passes `st_data` through unchanged.
- R6: A signed byte load (`req_unsigned`=0) returns the byte in lane `addr[1:0]` in bits [7:0] and copies its bit 7 into all upper bits.
- R7: An unsigned byte or halfword load (`req_unsigned`=1) fills every bit above the loaded value with zero.
- R8: A halfword load at an even offset returns lanes off+1:off in bits [15:0]; when signed, bit 15 of that value fills the upper bits.
- R9: A full-word load at offset 0 returns `ld_word` unchanged, whatever `req_unsigned` is.
- R10: A halfword access with an odd address, a full-word access with a nonzero offset, or any access with size code 3 sets `rsp_fault`, clears `rsp_be` and returns `rsp_rdata` of 0.
- R11: A load never asserts any bit of `rsp_be`, and a load returns `rsp_wdata` of 0; a store returns `rsp_rdata` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 full word, 3 reserved |
| req_unsigned | input | 1 | 1 zero-extends a sub-word load, 0 sign-extends it |
| req_addr | input | ADDR_W | Byte address; the low bits select the lane |
| st_data | input | DATA_W | Source register value for stores |
| ld_word | input | DATA_W | Word fetched from memory for loads |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_fault | output | 1 | The access was misaligned or used a reserved size |
| rsp_be | output | DATA_W/8 | Byte write enables, one per lane |
| rsp_wdata | output | DATA_W | Store data copied into every lane |
| rsp_rdata | output | DATA_W | Extended load result |

## Verification
The bench builds the unit with DATA_W=32 and ADDR_W=32. With four lanes, a sweep over all four offsets, every size code and both signedness settings covers every lane-select and mask shift. It also hits every misaligned combination, including a halfword at offset 3, whose mask would otherwise run off the top lane. Data patterns with bit 7 or bit 15 set or clear in each lane test that sign and zero extension take the fill bit from the correct lane.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_FULL = 2'd2,
    SZ_RSVD = 2'd3
  } lsa_size_e;
endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check #(
  parameter int LANES  = 4,
  parameter int OFFS_W = 2
) (
  input  lsa_pkg::lsa_size_e size,
  input  logic [OFFS_W-1:0]  off,
  output logic               misaligned
);
  import lsa_pkg::*;

  function automatic logic bad_align(lsa_size_e s, logic [OFFS_W-1:0] o);
    case (s)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return o[0];
      SZ_FULL: return (o != '0);
      default: return 1'b1;
    endcase
  endfunction

  assign misaligned = bad_align(size, off);
endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFFS_W = 2
) (
  input  lsa_pkg::lsa_size_e size,
  input  logic [OFFS_W-1:0]  off,
  input  logic [DATA_W-1:0]  st_data,
  output logic [LANES-1:0]   be,
  output logic [DATA_W-1:0]  wdata
);
  import lsa_pkg::*;

  localparam int HALVES = LANES / 2;

  function automatic logic [LANES-1:0] lane_mask(lsa_size_e s, logic [OFFS_W-1:0] o);
    logic [LANES-1:0] one_lane;
    logic [LANES-1:0] two_lane;
    one_lane = {{(LANES-1){1'b0}}, 1'b1};
    two_lane = {{(LANES-2){1'b0}}, 2'b11};
    case (s)
      SZ_BYTE: return one_lane << o;
      SZ_HALF: return two_lane << o;
      SZ_FULL: return {LANES{1'b1}};
      default: return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] spread(lsa_size_e s, logic [DATA_W-1:0] d);
    case (s)
      SZ_BYTE: return {LANES{d[7:0]}};
      SZ_HALF: return {HALVES{d[15:0]}};
      default: return d;
    endcase
  endfunction

  assign be    = lane_mask(size, off);
  assign wdata = spread(size, st_data);
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract #(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 2
) (
  input  lsa_pkg::lsa_size_e size,
  input  logic [OFFS_W-1:0]  off,
  input  logic               uns,
  input  logic [DATA_W-1:0]  ld_word,
  output logic [DATA_W-1:0]  rdata
);
  import lsa_pkg::*;

  function automatic logic [DATA_W-1:0] extend(lsa_size_e s, logic u,
                                               logic [DATA_W-1:0] sh);
    logic fill;
    case (s)
      SZ_BYTE: begin
        fill = ~u & sh[7];
        return {{(DATA_W-8){fill}}, sh[7:0]};
      end
      SZ_HALF: begin
        fill = ~u & sh[15];
        return {{(DATA_W-16){fill}}, sh[15:0]};
      end
      default: return sh;
    endcase
  endfunction

  logic [DATA_W-1:0] shifted;
  assign shifted = ld_word >> {off, 3'b000};
  assign rdata   = extend(size, uns, shifted);
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_store,
  input  logic [1:0]          req_size,
  input  logic                req_unsigned,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   st_data,
  input  logic [DATA_W-1:0]   ld_word,
  output logic                rsp_valid,
  output logic                rsp_fault,
  output logic [DATA_W/8-1:0] rsp_be,
  output logic [DATA_W-1:0]   rsp_wdata,
  output logic [DATA_W-1:0]   rsp_rdata
);
  import lsa_pkg::*;

  localparam int LANES  = DATA_W / 8;
  localparam int OFFS_W = $clog2(LANES);

  lsa_size_e          size;
  logic [OFFS_W-1:0]  off;
  logic               unused_addr_hi;
  assign size           = lsa_size_e'(req_size);
  assign off            = req_addr[OFFS_W-1:0];
  assign unused_addr_hi = ^req_addr[ADDR_W-1:OFFS_W];

  // Named internal events for the assertions
  logic               ev_misaligned;
  logic [LANES-1:0]   ev_lane_be;
  logic [DATA_W-1:0]  ev_lane_wdata;
  logic [DATA_W-1:0]  ev_ext_rdata;
  logic               rsp_store;

  lsa_align_check #(.LANES(LANES), .OFFS_W(OFFS_W)) u_align (
    .size(size), .off(off), .misaligned(ev_misaligned)
  );

  lsa_store_lane #(.DATA_W(DATA_W), .LANES(LANES), .OFFS_W(OFFS_W)) u_store (
    .size(size), .off(off), .st_data(st_data),
    .be(ev_lane_be), .wdata(ev_lane_wdata)
  );

  lsa_load_extract #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_load (
    .size(size), .off(off), .uns(req_unsigned), .ld_word(ld_word),
    .rdata(ev_ext_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_store <= 1'b0;
      rsp_be    <= '0;
      rsp_wdata <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_store <= req_valid & req_store;
      rsp_fault <= req_valid & ev_misaligned;
      rsp_be    <= (req_valid && req_store && !ev_misaligned) ? ev_lane_be : '0;
      rsp_wdata <= (req_valid && req_store) ? ev_lane_wdata : '0;
      rsp_rdata <= (req_valid && !req_store && !ev_misaligned) ? ev_ext_rdata : '0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_be == '0 && !rsp_fault)); // R1
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_STORE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_store && !rsp_fault) |->
      ($countones(rsp_be) == 1 || $countones(rsp_be) == 2 ||
       $countones(rsp_be) == LANES)); // R3
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_be == '0 && rsp_rdata == '0)); // R10
  AST_LOAD_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store) |=> (rsp_be == '0 && rsp_wdata == '0)); // R11
endmodule

// File: tb/lsa_unit_test.sv
module lsa_unit_test;
  localparam int DW = 32;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_store = 1'b0;
  logic [1:0]    req_size = '0;
  logic          req_unsigned = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [DW-1:0] ld_word = '0;
  logic          rsp_valid, rsp_fault;
  logic [3:0]    rsp_be;
  logic [DW-1:0] rsp_wdata, rsp_rdata;

  always #5 clk = ~clk;

  lsa_unit #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
    .st_data(st_data), .ld_word(ld_word), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_be(rsp_be), .rsp_wdata(rsp_wdata),
    .rsp_rdata(rsp_rdata)
  );

  typedef struct {
    int          due;
    logic        fault;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] rdata;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Driver: computes the expected response from the requirements and queues it
  task automatic drive(bit st, int sz, bit uns, logic [31:0] addr,
                       logic [31:0] sd, logic [31:0] lw);
    exp_t e;
    int   off, n;
    logic [31:0] v;
    off = int'(addr[1:0]);
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    @(posedge clk); #1;
    req_valid = 1'b1; req_store = st; req_size = sz[1:0];
    req_unsigned = uns; req_addr = addr; st_data = sd; ld_word = lw;
    e.due = cyc + 1;
    e.fault = (sz == 3) || (sz == 1 && off % 2 == 1) || (sz == 2 && off != 0);
    e.be = '0; e.wdata = '0; e.rdata = '0;
    if (st) begin
      for (int i = 0; i < 4; i++) begin
        if (!e.fault && i >= off && i < off + n) e.be[i] = 1'b1;
        if (sz == 0) e.wdata[8*i +: 8] = sd[7:0];
        else if (sz == 1) e.wdata[8*i +: 8] = sd[8*(i%2) +: 8];
        else e.wdata[8*i +: 8] = sd[8*i +: 8];
      end
    end else if (!e.fault) begin
      v = '0;
      for (int i = 0; i < n; i++) v[8*i +: 8] = lw[8*(off+i) +: 8];
      if (!uns && n < 4 && v[8*n-1])
        for (int b = 8*n; b < 32; b++) v[b] = 1'b1;
      e.rdata = v;
    end
    if (e.fault) e.tag = "R10";
    else if (st) e.tag = (sz == 0) ? "R3" : (sz == 1) ? "R4" : "R5";
    else if (sz == 2) e.tag = "R9 R11";
    else if (uns) e.tag = (sz == 0) ? "R7 R6 R11" : "R7 R8 R11";
    else e.tag = (sz == 0) ? "R6 R11" : "R8 R11";
    q.push_back(e);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Monitor: pops expected items in the cycle each one is due
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() != 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (!rsp_valid) begin
          errors++;
          $display("FAIL R2: rsp_valid act=%0b exp=1", rsp_valid);
        end else if (rsp_fault !== e.fault || rsp_be !== e.be ||
                     rsp_wdata !== e.wdata || rsp_rdata !== e.rdata) begin
          errors++;
          $display("FAIL %s: act fault=%0b be=%b wd=%h rd=%h exp fault=%0b be=%b wd=%h rd=%h",
                   e.tag, rsp_fault, rsp_be, rsp_wdata, rsp_rdata,
                   e.fault, e.be, e.wdata, e.rdata);
        end
      end else begin
        checks++;
        if (rsp_valid !== 1'b0 || rsp_be !== 4'b0 || rsp_fault !== 1'b0) begin
          errors++;
          $display("FAIL R1 R2: idle act valid=%0b be=%b fault=%0b exp 0 0000 0",
                   rsp_valid, rsp_be, rsp_fault);
        end
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        repeat (100000) @(posedge clk);
        wd = 1;
      end
      begin
        logic [31:0] pats [4];
        pats[0] = 32'h80FF_7F01;
        pats[1] = 32'h0180_80FF;
        pats[2] = 32'hA5C3_8E71;
        pats[3] = 32'h7F7F_0000;
        repeat (3) @(negedge clk);
        checks++; // R1 reset state
        if (rsp_valid !== 1'b0 || rsp_be !== 4'b0 || rsp_fault !== 1'b0) begin
          errors++;
          $display("FAIL R1: reset act valid=%0b be=%b fault=%0b exp 0 0000 0",
                   rsp_valid, rsp_be, rsp_fault);
        end
        @(posedge clk); #1 rst_n = 1'b1;
        for (int p = 0; p < 4; p++)
          for (int sz = 0; sz < 4; sz++)
            for (int o = 0; o < 4; o++) begin
              drive(1'b1, sz, 1'b0, {24'h1000_00, 6'd0, o[1:0]},
                    pats[p] ^ 32'h3C5A_9669, pats[(p+1)%4]);
              drive(1'b0, sz, 1'b0, {28'h2000_000, 2'd0, o[1:0]},
                    pats[(p+2)%4], pats[p]);
              drive(1'b0, sz, 1'b1, {28'h3000_000, 2'd0, o[1:0]},
                    pats[(p+3)%4], pats[p]);
              if (o == 2) idle();
            end
        idle();
        repeat (4) @(posedge clk);
      end
    join_any
    if (wd != 0) begin
      errors++;
      $display("FAIL watchdog: act=expired exp=completed");
    end
    done = 1;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2: pending act=%0d exp=0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule